// File: doc/BRIEF.md
# One-way security lockout register block

This block is a small set of configuration registers that sits on the primary processor's register bus during boot. Two protection registers hold bits that can only be set: once boot firmware sets one, the matching region (the primary core's upper boot ROM, the one-time-programmable fuse area, or the secondary core's upper boot ROM) stays hidden until the next hard reset. A write only adds bits to what is already set, so later firmware stages cannot reopen a region that an earlier stage closed. Setting the primary-core ROM bit also opens main RAM to that core.

A third register holds the secondary core in reset. Boot firmware lets the core run by clearing that bit, and no later write can put the core back into reset. A 32-bit boot-environment word records which kind of firmware ran before. It clears only on a cold reset and keeps its value through a warm reset, so firmware that starts after a warm restart can read what ran before it.

The hide flags and the active-low secondary-core reset are driven straight from the register bits. Reads are registered and return the addressed value on the cycle after the read request.

Top module: `lockout_regs`

## Requirements
- R1: After a cold reset, hide_rom9, hide_otp and hide_rom11 are 0, core11_rst_n is 0 (secondary core held), the boot-environment word is 0 and rdata is 0.
- R2: A write to offset 0x000 ORs wdata[1:0] into the primary protection register. Bit 0 drives hide_rom9, which also opens main RAM to the primary core. Bit 1 drives hide_otp. Writing 0x2 while the register holds 0x1 leaves 0x3.
- R3: No write clears a primary protection bit that is 1. It stays 1 until a warm or cold reset.
- R4: A write to offset 0x001 ORs wdata[0] into the secondary protection bit, which drives hide_rom11. That bit is also set-only, and wdata[7:1] has no effect.
- R5: A write to offset 0x002 with wdata[0]=0 clears the hold bit, which sets core11_rst_n to 1. Once the bit is cleared, writing wdata[0]=1 does not set it again. Writing 1 while the bit is still set leaves the core held.
- R6: hide_rom9, hide_otp, hide_rom11 and core11_rst_n change at the same clock edge that captures the write.
- R7: The 32-bit boot-environment word at offset 0x010 takes the full wdata on a write. A warm reset leaves it unchanged. Software uses the values 1, 3 and 7 as launch-mode codes.
- R8: A warm reset sets both protection registers to 0 and the hold bit to 1, exactly as a cold reset does.
- R9: When rd_en is high at a clock edge, rdata shows the addressed register on the next cycle and then holds. Offset 0x000 reads {30'b0, otp, rom9}. Offsets 0x001 and 0x002 read their single bit in bit 0 with zeros above it. Unmapped offsets read 0, and writes to them change nothing.
- R10: A read and a write to the same offset in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low, clears everything |
| warm_rst_n | input | 1 | Synchronous warm reset, active low, spares the boot-environment word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset within the block |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| hide_rom9 | output | 1 | Hide the primary-core upper boot ROM and open main RAM to it |
| hide_otp | output | 1 | Hide the fuse area |
| hide_rom11 | output | 1 | Hide the secondary-core upper boot ROM |
| core11_rst_n | output | 1 | Secondary-core reset, active low |

## Verification
The assertions check the one-way rules on every cycle outside reset: a hide flag that is high stays high, and a released secondary core stays released. They also check that the boot-environment word changes only on its own write strobe (warm resets included), that a warm reset restores the locked-down state, and that unmapped reads return zero. Only the bench scenarios can show the arithmetic itself. Those scenarios cover OR-accumulation to 0x3, ignored upper data bits, a write of 1 after release, the ordering of a read and a write in the same cycle, and a boot-environment value that survives a warm reset but not a cold one.

// File: rtl/lockout_pkg.sv
package lockout_pkg;
  localparam int NUM_REGS   = 4;
  localparam int IDX_PROT9  = 0;
  localparam int IDX_PROT11 = 1;
  localparam int IDX_HOLD11 = 2;
  localparam int IDX_ENV    = 3;

  // Byte offset of each register within the block.
  function automatic int unsigned reg_offset(input int idx);
    case (idx)
      IDX_PROT9:  return 32'h000;
      IDX_PROT11: return 32'h001;
      IDX_HOLD11: return 32'h002;
      default:    return 32'h010;
    endcase
  endfunction

  // Set-only bit: a write can raise it, nothing but reset lowers it.
  function automatic logic set_only_next(input logic cur, input logic wbit, input logic hit);
    return cur | (hit & wbit);
  endfunction

  // Clear-only bit: a write can lower it, nothing but reset raises it.
  function automatic logic clear_only_next(input logic cur, input logic wbit, input logic hit);
    return cur & ~(hit & ~wbit);
  endfunction
endpackage

// File: rtl/lockout_addr_decode.sv
module lockout_addr_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               wr_en,
  input  logic                               rd_en,
  output logic [lockout_pkg::NUM_REGS-1:0]   hit,
  output logic [lockout_pkg::NUM_REGS-1:0]   wr_hit,
  output logic                               rd_any
);
  for (genvar i = 0; i < lockout_pkg::NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(lockout_pkg::reg_offset(i));
    assign hit[i]    = (addr == OFF);
    assign wr_hit[i] = wr_en & hit[i];
  end
  assign rd_any = rd_en;
endmodule

// File: rtl/lockout_set_only_bits.sv
module lockout_set_only_bits #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wbits,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[b] <= 1'b0;
      else        q[b] <= lockout_pkg::set_only_next(q[b], wbits[b], wr_hit);
    end
  end
endmodule

// File: rtl/lockout_clear_only_bit.sv
module lockout_clear_only_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wbit,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b1;
    else        q <= lockout_pkg::clear_only_next(q, wbit, wr_hit);
  end
endmodule

// File: rtl/lockout_retained_word.sv
module lockout_retained_word #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!cold_rst_n)  q <= '0;
    else if (wr_hit)  q <= wdata;
  end
endmodule

// File: rtl/lockout_regs.sv
module lockout_regs #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int PROT9_W  = 2,
  parameter int PROT11_W = 1
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hide_rom9,
  output logic              hide_otp,
  output logic              hide_rom11,
  output logic              core11_rst_n
);
  import lockout_pkg::*;

  localparam int PAD9  = DATA_W - PROT9_W;
  localparam int PAD11 = DATA_W - PROT11_W;
  localparam int PADH  = DATA_W - 1;

  logic                hard_rst_n;
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic                rd_any;
  logic                addr_mapped;
  logic                env_wr;
  logic [PROT9_W-1:0]  prot9_q;
  logic [PROT11_W-1:0] prot11_q;
  logic                hold11_q;
  logic [DATA_W-1:0]   env_q;
  logic [DATA_W-1:0]   view [NUM_REGS];
  logic [DATA_W-1:0]   rd_value;

  // Protection and hold bits treat either reset as a hard reset.
  assign hard_rst_n = cold_rst_n & warm_rst_n;

  lockout_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .hit(hit), .wr_hit(wr_hit), .rd_any(rd_any)
  );

  assign addr_mapped = |hit;
  assign env_wr      = wr_hit[IDX_ENV];

  lockout_set_only_bits #(.WIDTH(PROT9_W)) u_prot9 (
    .clk(clk), .rst_n(hard_rst_n), .wr_hit(wr_hit[IDX_PROT9]),
    .wbits(wdata[PROT9_W-1:0]), .q(prot9_q)
  );

  lockout_set_only_bits #(.WIDTH(PROT11_W)) u_prot11 (
    .clk(clk), .rst_n(hard_rst_n), .wr_hit(wr_hit[IDX_PROT11]),
    .wbits(wdata[PROT11_W-1:0]), .q(prot11_q)
  );

  lockout_clear_only_bit u_hold11 (
    .clk(clk), .rst_n(hard_rst_n), .wr_hit(wr_hit[IDX_HOLD11]),
    .wbit(wdata[0]), .q(hold11_q)
  );

  lockout_retained_word #(.WIDTH(DATA_W)) u_env (
    .clk(clk), .cold_rst_n(cold_rst_n), .wr_hit(env_wr),
    .wdata(wdata), .q(env_q)
  );

  assign view[IDX_PROT9]  = {{PAD9{1'b0}},  prot9_q};
  assign view[IDX_PROT11] = {{PAD11{1'b0}}, prot11_q};
  assign view[IDX_HOLD11] = {{PADH{1'b0}},  hold11_q};
  assign view[IDX_ENV]    = env_q;

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rd_value = rd_value | view[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!hard_rst_n)  rdata <= '0;
    else if (rd_any)  rdata <= rd_value;
  end

  assign hide_rom9    = prot9_q[0];
  assign hide_otp     = prot9_q[1];
  assign hide_rom11   = prot11_q[0];
  assign core11_rst_n = ~hold11_q;
endmodule

// File: rtl/lockout_regs_checker.sv
module lockout_regs_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              warm_rst_n,
  input logic              rd_en,
  input logic              addr_mapped,
  input logic              env_wr,
  input logic [DATA_W-1:0] env_q,
  input logic [DATA_W-1:0] rdata,
  input logic              hide_rom9,
  input logic              hide_otp,
  input logic              hide_rom11,
  input logic              core11_rst_n
);
  p_rom9_sticky_r3: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    hide_rom9 |=> hide_rom9);
  p_otp_sticky_r3: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    hide_otp |=> hide_otp);
  p_rom11_sticky_r4: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    hide_rom11 |=> hide_rom11);
  p_release_final_r5: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    core11_rst_n |=> core11_rst_n);
  p_env_retained_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !env_wr |=> $stable(env_q));
  p_warm_lockdown_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> (!hide_rom9 && !hide_otp && !hide_rom11 && !core11_rst_n));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (rd_en && !addr_mapped) |=> (rdata == '0));
endmodule

bind lockout_regs lockout_regs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
  .rd_en(rd_en), .addr_mapped(addr_mapped), .env_wr(env_wr), .env_q(env_q),
  .rdata(rdata), .hide_rom9(hide_rom9), .hide_otp(hide_otp),
  .hide_rom11(hide_rom11), .core11_rst_n(core11_rst_n)
);

// File: tb/lockout_regs_test.sv
`timescale 1ns/1ps
module lockout_regs_test;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hide_rom9, hide_otp, hide_rom11, core11_rst_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model state (behavioural).
  int unsigned m_prot9  = 0;
  int unsigned m_prot11 = 0;
  int unsigned m_hold   = 1;
  int unsigned m_env    = 0;
  int unsigned m_rd     = 0;

  always #2 clk = ~clk;

  lockout_regs uut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hide_rom9(hide_rom9), .hide_otp(hide_otp), .hide_rom11(hide_rom11),
    .core11_rst_n(core11_rst_n)
  );

  function automatic int unsigned model_peek(input int unsigned a);
    if (a == 0)  return m_prot9;
    if (a == 1)  return m_prot11;
    if (a == 2)  return m_hold;
    if (a == 16) return m_env;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!cold_rst_n) begin
      m_prot9 = 0; m_prot11 = 0; m_hold = 1; m_env = 0; m_rd = 0;
    end else if (!warm_rst_n) begin
      m_prot9 = 0; m_prot11 = 0; m_hold = 1; m_rd = 0;
    end else begin
      if (rd_en) m_rd = model_peek(int'(addr));
      if (wr_en) begin
        case (int'(addr))
          0:  m_prot9  = m_prot9 | (wdata % 4);
          1:  m_prot11 = m_prot11 | (wdata % 2);
          2:  if (wdata % 2 == 0) m_hold = 0;
          16: m_env = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (cycles > 0 && !done) begin
      chk(cur_req, "hide_rom9",    {31'b0, hide_rom9},    m_prot9 % 2);
      chk(cur_req, "hide_otp",     {31'b0, hide_otp},     (m_prot9 / 2) % 2);
      chk(cur_req, "hide_rom11",   {31'b0, hide_rom11},   m_prot11);
      chk(cur_req, "core11_rst_n", {31'b0, core11_rst_n}, (m_hold == 0) ? 1 : 0);
      chk(cur_req, "rdata",        rdata,                  m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = 12'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, "read", rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    chk("R1", "core11_rst_n", {31'b0, core11_rst_n}, 0);
    chk("R1", "hide_rom9", {31'b0, hide_rom9}, 0);
    rd("R1", 16, 0);
    rd("R1", 2, 1);

    // R2 / R6: OR accumulation, immediate outputs
    cur_req = "R2";
    wr(0, 1);
    chk("R6", "hide_rom9 after write", {31'b0, hide_rom9}, 1);
    wr(0, 2);
    rd("R2", 0, 3);
    // R3: zero writes and high garbage do not clear
    cur_req = "R3";
    wr(0, 0);
    wr(0, 32'hFFFF_FFFC);
    rd("R3", 0, 3);

    // R4
    cur_req = "R4";
    wr(1, 32'hFE);
    rd("R4", 1, 0);
    wr(1, 1);
    wr(1, 0);
    rd("R4", 1, 1);

    // R5
    cur_req = "R5";
    wr(2, 1);
    chk("R5", "held after write 1", {31'b0, core11_rst_n}, 0);
    wr(2, 32'hFFFF_FFFE);
    chk("R5", "released", {31'b0, core11_rst_n}, 1);
    wr(2, 1);
    rd("R5", 2, 0);

    // R9: unmapped
    cur_req = "R9";
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    wr(17, 32'hFFFF_FFFF);
    wr(12'hFFF, 32'hFFFF_FFFF);
    rd("R9", 12'hFFF, 0);
    rd("R9", 3, 0);
    rd("R9", 16, 0);

    // R10: read and write in one cycle
    cur_req = "R10";
    wr(16, 3);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 12'h010; wdata = 7;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R10", "old value", rdata, 3);
    rd("R7", 16, 7);

    // R7 / R8: warm reset keeps env, relocks the rest
    cur_req = "R8";
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    chk("R8", "hide_otp", {31'b0, hide_otp}, 0);
    chk("R8", "core11_rst_n", {31'b0, core11_rst_n}, 0);
    rd("R8", 0, 0);
    cur_req = "R7";
    rd("R7", 16, 7);
    wr(16, 32'hA5A5_0001);
    rd("R7", 16, 32'hA5A5_0001);

    // R1: cold reset clears env
    cur_req = "R1";
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); cold_rst_n = 1'b1;
    rd("R1", 16, 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule